// File: doc/BRIEF.md
# Framebuffer Control, Status and Interrupt Register Window

This block is the small byte-wide register window of a framebuffer controller. It sits in the upper half of a 32-byte offset space, at offsets 0x10 to 0x1F. The window holds a control byte, a status byte that reports an interrupt-pending flag next to fixed board-identification bits, and fourteen general storage bytes. The surrounding controller uses those storage bytes for cursor start, cursor end and video-control settings.

A one-cycle vertical-sync event from the display timing logic raises a level interrupt when the enable bit in the control byte is set. The interrupt stays high until software writes the status byte, with any data value.

Reads are registered: the data appears one cycle after the request, with a valid strobe. The lower half of the offset space belongs to other logic. In this block it reads as zero, and writes there are dropped.

Top module: `fbc_ctl_regs`

## Requirements
- R1: After synchronous reset, irq is low, rd_valid is low, the control byte (offset 0x10) reads 0x00, the status byte (offset 0x11) reads 0x61, and every storage byte at 0x12 to 0x1F reads 0x00.
- R2: A write to offset 0x10 stores all eight data bits, and a later read of 0x10 returns them unchanged.
- R3: A vsync_evt cycle while control bit 7 is 1 sets the pending flag, and irq is high from the clock edge that samples the event.
- R4: A vsync_evt cycle while control bit 7 is 0 leaves irq low and the pending flag clear.
- R5: A read of offset 0x11 returns 0x61 with bit 7 equal to the pending flag, so it returns 0xE1 while an interrupt is pending.
- R6: A write of any value to offset 0x11 clears the pending flag and drops irq at that edge. The written data is ignored, so a write of 0xFF while nothing is pending leaves irq low.
- R7: When a status write and an enabled vsync_evt fall in the same cycle, the set wins and irq stays high.
- R8: Offsets 0x12 through 0x1F are independent read/write bytes. A write to one changes no other.
- R9: Reads of offsets 0x00 to 0x0F return 0x00, and writes to them change no mapped byte and raise no interrupt.
- R10: Read data and rd_valid appear exactly one cycle after the cycle in which rd_en is sampled. rd_valid is low in every cycle that does not follow a read request.
- R11: Clearing control bit 7 while an interrupt is pending does not clear it. Only a status write does.
- R12: irq is a level: it stays high across further vsync events and idle cycles until a status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte at addr |
| rd_en | input | 1 | Read request for the byte at addr |
| addr | input | ADDR_W (5) | Byte offset within the 32-byte space |
| wdata | input | DATA_W (8) | Write data |
| vsync_evt | input | 1 | One-cycle vertical-sync event |
| rdata | output | DATA_W (8) | Registered read data |
| rd_valid | output | 1 | High in the cycle rdata carries a read result |
| irq | output | 1 | Level interrupt, registered |

## Verification
Every result of this block is due one clock edge after its stimulus is sampled. A write or a vsync event changes irq and the stored bytes at the sampling edge. A read request presents rdata and rd_valid after the next edge. The bench drives each stimulus on a falling edge and holds it for one full period. It then samples the outputs on the following falling edge, which lies one rising edge after the stimulus. The bench also checks rd_valid low in the cycle after that, to confirm the one-cycle read latency.

// File: rtl/fbc_regs_pkg.sv
package fbc_regs_pkg;
  // Index of each register inside the upper window (offset minus window base)
  localparam int unsigned CTRL_IDX   = 0;
  localparam int unsigned STAT_IDX   = 1;
  localparam int unsigned GEN_IDX0   = 2;
  // Control bit that allows vsync to raise the interrupt
  localparam int unsigned IRQ_EN_BIT = 7;
  // Constant identification bits returned by every status read
  localparam logic [7:0]  STAT_ID    = 8'h61;
endpackage

// File: rtl/fbc_reg_bank.sv
module fbc_reg_bank
  import fbc_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int IDX_W = ADDR_W - 1,
  localparam int NUM_GEN = (1 << IDX_W) - GEN_IDX0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_sel,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                ctrl_q,
  output logic [NUM_GEN-1:0][DATA_W-1:0]   gen_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_sel && (wr_idx == IDX_W'(CTRL_IDX))) begin
      ctrl_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_store
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '0;
      end else if (wr_sel && (wr_idx == IDX_W'(GEN_IDX0 + g))) begin
        byte_q <= wdata;
      end
    end
    assign gen_q[g] = byte_q;
  end

endmodule

// File: rtl/fbc_irq_ctl.sv
module fbc_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic vsync_evt,
  input  logic irq_en,
  input  logic ack,
  output logic pend_q
);

  // Set has priority over acknowledge so a coincident event is kept
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (vsync_evt && irq_en) begin
      pend_q <= 1'b1;
    end else if (ack) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fbc_rd_port.sv
module fbc_rd_port
  import fbc_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int IDX_W = ADDR_W - 1,
  localparam int NUM_GEN = (1 << IDX_W) - GEN_IDX0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic                           mapped,
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [DATA_W-1:0]              ctrl_q,
  input  logic                           pend_q,
  input  logic [NUM_GEN-1:0][DATA_W-1:0] gen_q,
  output logic [DATA_W-1:0]              rdata_q,
  output logic                           rd_valid_q
);

  localparam logic [DATA_W-1:0] ID_BITS = DATA_W'(STAT_ID);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      if (rd_idx == IDX_W'(CTRL_IDX)) begin
        rd_mux = ctrl_q;
      end else if (rd_idx == IDX_W'(STAT_IDX)) begin
        rd_mux = ID_BITS;
        rd_mux[DATA_W-1] = pend_q;
      end else begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (rd_idx == IDX_W'(GEN_IDX0 + i)) rd_mux = gen_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

endmodule

// File: rtl/fbc_ctl_regs.sv
module fbc_ctl_regs
  import fbc_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vsync_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq
);

  localparam int IDX_W   = ADDR_W - 1;
  localparam int NUM_GEN = (1 << IDX_W) - GEN_IDX0;

  logic                           mapped;
  logic [IDX_W-1:0]               idx;
  logic                           wr_sel;
  logic                           ack;
  logic [DATA_W-1:0]              ctrl_q;
  logic [NUM_GEN-1:0][DATA_W-1:0] gen_q;
  logic                           pend_q;

  // The window occupies the upper half of the offset space
  assign mapped = addr[ADDR_W-1];
  assign idx    = addr[IDX_W-1:0];
  assign wr_sel = wr_en && mapped;
  assign ack    = wr_sel && (idx == IDX_W'(STAT_IDX));

  fbc_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wr_idx (idx),
    .wdata  (wdata),
    .ctrl_q (ctrl_q),
    .gen_q  (gen_q)
  );

  fbc_irq_ctl u_irq (
    .clk       (clk),
    .rst       (rst),
    .vsync_evt (vsync_evt),
    .irq_en    (ctrl_q[IRQ_EN_BIT]),
    .ack       (ack),
    .pend_q    (pend_q)
  );

  fbc_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .mapped     (mapped),
    .rd_idx     (idx),
    .ctrl_q     (ctrl_q),
    .pend_q     (pend_q),
    .gen_q      (gen_q),
    .rdata_q    (rdata),
    .rd_valid_q (rd_valid)
  );

  assign irq = pend_q;

endmodule

// File: rtl/fbc_ctl_regs_chk.sv
module fbc_ctl_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              vsync_evt,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic              irq,
  input logic [DATA_W-1:0] ctrl_q
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'((1 << (ADDR_W - 1)) + 1);

  logic armed;
  logic stat_wr;
  assign armed   = vsync_evt && ctrl_q[7];
  assign stat_wr = wr_en && (addr == STAT_ADDR);

  // R1: reset leaves the interrupt and the read strobe low
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && !rd_valid));

  a_r3_set_on_vsync: assert property (@(posedge clk) disable iff (rst)
    armed |=> irq);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!irq && !armed) |=> !irq);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !armed) |=> !irq);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && armed) |=> irq);

  a_r12_level_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_wr) |=> irq);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  a_r5_status_id: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == STAT_ADDR)) |=> (rdata[6:0] == 7'h61));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr[ADDR_W-1]) |=> (rdata == '0));

endmodule

bind fbc_ctl_regs fbc_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .vsync_evt (vsync_evt),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .irq       (irq),
  .ctrl_q    (ctrl_q)
);

// File: tb/fbc_ctl_regs_bench.sv
`timescale 1ns/1ps
module fbc_ctl_regs_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       vsync_evt = 1'b0;
  logic [7:0] rdata;
  logic       rd_valid;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fbc_ctl_regs u_fbc_ctl_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .vsync_evt (vsync_evt),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Stimulus on a falling edge, held for one period; effects seen one falling edge later
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 valid", {7'b0, rd_valid}, 8'h01);
    d = rdata;
  endtask

  task automatic vsync_pulse();
    @(negedge clk);
    vsync_evt = 1'b1;
    @(negedge clk);
    vsync_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    rd(5'h10, d); chk("R1 ctrl", d, 8'h00);
    rd(5'h11, d); chk("R1 status", d, 8'h61);
    for (int i = 18; i < 32; i++) begin
      rd(5'(i), d); chk("R1 store", d, 8'h00);
    end
  endtask

  task automatic t_read_latency();
    logic [7:0] d;
    rd(5'h11, d);
    @(negedge clk);
    chk("R10 idle", {7'b0, rd_valid}, 8'h00);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] d;
    wr(5'h10, 8'h5A); rd(5'h10, d); chk("R2 ctrl", d, 8'h5A);
    wr(5'h10, 8'hA5); rd(5'h10, d); chk("R2 ctrl", d, 8'hA5);
  endtask

  task automatic t_vsync_disabled();
    logic [7:0] d;
    wr(5'h10, 8'h7F);
    vsync_pulse();
    chk("R4 irq", {7'b0, irq}, 8'h00);
    rd(5'h11, d); chk("R4 status", d, 8'h61);
  endtask

  task automatic t_vsync_enabled();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    vsync_pulse();
    chk("R3 irq", {7'b0, irq}, 8'h01);
    rd(5'h11, d); chk("R5 status pending", d, 8'hE1);
    vsync_pulse();
    repeat (3) @(negedge clk);
    chk("R12 level", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(5'h11, 8'h00);
    chk("R6 ack", {7'b0, irq}, 8'h00);
    rd(5'h11, d); chk("R6 status", d, 8'h61);
    wr(5'h11, 8'hFF);
    chk("R6 data ignored", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_collision();
    @(negedge clk);
    vsync_evt = 1'b1; wr_en = 1'b1; addr = 5'h11; wdata = 8'h00;
    @(negedge clk);
    vsync_evt = 1'b0; wr_en = 1'b0;
    chk("R7 set wins", {7'b0, irq}, 8'h01);
    wr(5'h11, 8'h00);
    chk("R7 then ack", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_en_clear_keeps();
    vsync_pulse();
    chk("R11 set", {7'b0, irq}, 8'h01);
    wr(5'h10, 8'h00);
    chk("R11 kept", {7'b0, irq}, 8'h01);
    wr(5'h11, 8'h3C);
    chk("R11 ack", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_store();
    logic [7:0] d;
    for (int i = 18; i < 32; i++) wr(5'(i), 8'(i * 7 + 3));
    wr(5'h14, 8'hC3);
    for (int i = 18; i < 32; i++) begin
      rd(5'(i), d);
      chk("R8 store", d, (i == 20) ? 8'hC3 : 8'(i * 7 + 3));
    end
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(5'h10, 8'h80);
    for (int i = 0; i < 16; i++) wr(5'(i), 8'hFF);
    chk("R9 no irq", {7'b0, irq}, 8'h00);
    rd(5'h02, d); chk("R9 read zero", d, 8'h00);
    rd(5'h0F, d); chk("R9 read zero", d, 8'h00);
    rd(5'h12, d); chk("R9 store intact", d, 8'(18 * 7 + 3));
    rd(5'h10, d); chk("R9 ctrl intact", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_latency();
    t_ctrl_rw();
    t_vsync_disabled();
    t_vsync_enabled();
    t_ack();
    t_collision();
    t_en_clear_keeps();
    t_store();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule